// File: doc/BRIEF.md
# Skewed Pipelined Adder

This block adds two 32-bit operands and a one-bit carry-in through a pipeline that accepts a fresh operand pair on every clock. The carry chain is cut into byte-wide slices. Each slice does its 8-bit addition in its own cycle and registers the carry it produces. The next slice picks up that carry one cycle later. The upper operand bytes pass through staircase delay registers, so each byte meets its incoming carry in the same cycle. Finished low result bytes are held back in a mirrored staircase, so the whole sum and the final carry-out leave together through one output register.

A valid flag travels beside the data through a delay of the same length, and it marks the output slots that carry real results. The datapath itself runs every cycle whatever the flag says. Throughput is one sum per clock, and the latency is fixed. The operand width and the slice width are parameters, and the number of slices and the latency follow from them.

Top module: `skew_pipe_adder`

## Requirements
- R1: For each accepted slot, {carry_out, sum} equals op_a + op_b + carry_in as a 33-bit unsigned value, with carry_out in bit 32.
- R2: Operands sampled at a rising edge reach the output register at the fifth rising edge after that one, and out_valid rises at that same edge.
- R3: A new operand pair is taken on every clock. Back-to-back valid slots give one correct result per cycle, in the order the operands arrived.
- R4: out_valid is high for a slot only if in_valid was high when that slot's operands were sampled. Idle slots never raise it.
- R5: A carry crosses every byte boundary correctly, including a ripple from bit 0 to carry_out (0xFFFFFFFF + 1 gives sum 0 with carry_out 1).
- R6: carry_in adds one at bit 0 (0x7FFFFFFF + 0x7FFFFFFF + 1 gives 0xFFFFFFFF with carry_out 0).
- R7: rst is synchronous and active high. After any edge with rst high, out_valid, sum and carry_out read 0. Operands in flight when reset arrives never produce a valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand pair on this cycle as real |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry added at bit 0 |
| out_valid | output | 1 | High when sum and carry_out hold a real result |
| sum | output | 32 | Registered 32-bit sum |
| carry_out | output | 1 | Registered carry out of bit 31 |

## Verification
Each result is due five rising edges after the edge that samples its operands. The bench drives on falling edges and reads on falling edges, so a pair driven at one falling edge is checked six falling edges later. A reference queue of six entries reproduces that offset: every cycle pushes the expected 33-bit total and the valid bit, and pops the entry that is due. When reset is driven, every queued entry is turned into an idle slot, so operands flushed by reset must show out_valid low at the cycles where they would have come out.

// File: rtl/spa_pkg.sv
package spa_pkg;

  // Default geometry of the adder
  localparam int unsigned SPA_WIDTH   = 32;
  localparam int unsigned SPA_SLICE_W = 8;

  // Number of carry-chain slices for a given total and slice width
  function automatic int unsigned spa_slices(input int unsigned width,
                                             input int unsigned slice_w);
    return width / slice_w;
  endfunction

  // Rising edges from operand sampling to the output register
  function automatic int unsigned spa_latency(input int unsigned width,
                                              input int unsigned slice_w);
    return (width / slice_w) + 1;
  endfunction

endpackage

// File: rtl/spa_delay_line.sv
// Plain shift register of DEPTH stages (DEPTH >= 1), cleared by sync reset.
module spa_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[DEPTH-1];

endmodule

// File: rtl/spa_slice_add.sv
// One byte-wide (SW) slice: registered sum and registered carry.
module spa_slice_add #(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] op_x,
  input  logic [SW-1:0] op_y,
  input  logic          cy_in,
  output logic [SW-1:0] sum_q,
  output logic          cy_q
);

  logic [SW:0] total;

  always_comb begin
    total = {1'b0, op_x} + {1'b0, op_y} + {{SW{1'b0}}, cy_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      sum_q <= total[SW-1:0];
      cy_q  <= total[SW];
    end
  end

endmodule

// File: rtl/skew_pipe_adder.sv
// Pipelined adder: carry chain split into SLICE_W slices, one per cycle.
// WIDTH must be a multiple of SLICE_W.
module skew_pipe_adder
  import spa_pkg::*;
#(
  parameter int unsigned WIDTH   = SPA_WIDTH,
  parameter int unsigned SLICE_W = SPA_SLICE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  localparam int unsigned NSLICE = spa_slices(WIDTH, SLICE_W);

  // Operand capture registers
  logic [WIDTH-1:0] a_q, b_q;
  logic             ci_q, v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      ci_q <= 1'b0;
      v_q  <= 1'b0;
    end else begin
      a_q  <= op_a;
      b_q  <= op_b;
      ci_q <= carry_in;
      v_q  <= in_valid;
    end
  end

  // Per-slice aligned operands, carries and results
  logic [NSLICE-1:0][SLICE_W-1:0] x_al, y_al, slc_sum, sum_al;
  logic [NSLICE-1:0]              cin_al, slc_cy;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    if (i == 0) begin : g_first
      assign x_al[i]   = a_q[SLICE_W-1:0];
      assign y_al[i]   = b_q[SLICE_W-1:0];
      assign cin_al[i] = ci_q;
    end else begin : g_skew
      logic [2*SLICE_W-1:0] skew_in, skew_out;
      assign skew_in = {a_q[i*SLICE_W +: SLICE_W], b_q[i*SLICE_W +: SLICE_W]};
      spa_delay_line #(.W(2*SLICE_W), .DEPTH(i)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .din  (skew_in),
        .dout (skew_out)
      );
      assign x_al[i]   = skew_out[2*SLICE_W-1:SLICE_W];
      assign y_al[i]   = skew_out[SLICE_W-1:0];
      assign cin_al[i] = slc_cy[i-1];
    end

    spa_slice_add #(.SW(SLICE_W)) u_add (
      .clk   (clk),
      .rst   (rst),
      .op_x  (x_al[i]),
      .op_y  (y_al[i]),
      .cy_in (cin_al[i]),
      .sum_q (slc_sum[i]),
      .cy_q  (slc_cy[i])
    );

    if (i == NSLICE - 1) begin : g_last
      assign sum_al[i] = slc_sum[i];
    end else begin : g_deskew
      spa_delay_line #(.W(SLICE_W), .DEPTH(NSLICE - 1 - i)) u_deskew (
        .clk  (clk),
        .rst  (rst),
        .din  (slc_sum[i]),
        .dout (sum_al[i])
      );
    end
  end

  // Valid tag follows the slices
  logic vld_al;

  spa_delay_line #(.W(1), .DEPTH(NSLICE)) u_vld (
    .clk  (clk),
    .rst  (rst),
    .din  (v_q),
    .dout (vld_al)
  );

  // Output register
  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      carry_out <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      sum       <= sum_al;
      carry_out <= slc_cy[NSLICE-1];
      out_valid <= vld_al;
    end
  end

endmodule

// File: rtl/spa_checker.sv
// Checker bound to the adder: compares outputs against a delayed plain sum.
module spa_checker
  import spa_pkg::*;
#(
  parameter int unsigned WIDTH   = SPA_WIDTH,
  parameter int unsigned SLICE_W = SPA_SLICE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out
);

  localparam int unsigned LAT = spa_latency(WIDTH, SLICE_W);

  logic           hist_v [LAT+1];
  logic [WIDTH:0] hist_r [LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= LAT; k++) begin
        hist_v[k] <= 1'b0;
        hist_r[k] <= '0;
      end
    end else begin
      hist_v[0] <= in_valid;
      hist_r[0] <= {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
      for (int k = 1; k <= LAT; k++) begin
        hist_v[k] <= hist_v[k-1];
        hist_r[k] <= hist_r[k-1];
      end
    end
  end

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (rst)
    hist_v[LAT] |-> ({carry_out, sum} == hist_r[LAT])); // R1

  AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    hist_v[LAT] |-> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !hist_v[LAT] |-> !out_valid); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && sum == '0 && !carry_out)); // R7

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (hist_v[LAT] && hist_v[LAT-1]) |=> out_valid); // R3

endmodule

bind skew_pipe_adder spa_checker #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_spa_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .sum       (sum),
  .carry_out (carry_out)
);

// File: tb/test_skew_pipe_adder.sv
module test_skew_pipe_adder;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  // Drive at a falling edge, captured at the next rising edge, result at the
  // fifth rising edge after capture: visible six falling edges after driving.
  localparam int DUE        = 6;

  typedef struct {
    bit           v;
    logic [W:0]   r;
    string        tag;
  } ent_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] sum;
  logic         carry_out;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  bit   prev_r  = 1'b1;
  ent_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_pipe_adder #(.WIDTH(W), .SLICE_W(8)) i_skew_pipe_adder (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .sum       (sum),
    .carry_out (carry_out)
  );

  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit c, input bit r, input string tag);
    ent_t e;
    @(negedge clk);
    // R7: state right after an edge taken with reset high
    if (prev_r) begin
      n_tests++;
      if (out_valid !== 1'b0 || sum !== '0 || carry_out !== 1'b0) begin
        n_fail++;
        $display("FAIL R7 reset state: got v=%b sum=%h co=%b exp v=0 sum=0 co=0",
                 out_valid, sum, carry_out);
      end
    end
    if (q.size() == DUE) begin
      e = q.pop_front();
      n_tests++;
      if (e.v) begin
        if (out_valid !== 1'b1) begin
          n_fail++;
          $display("FAIL R2 out_valid late/missing: got %b exp 1", out_valid);
        end else if ({carry_out, sum} !== e.r) begin
          n_fail++;
          $display("FAIL %s result: got %h exp %h", e.tag, {carry_out, sum}, e.r);
        end
      end else if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL %s idle slot flagged: got out_valid=%b exp 0", e.tag, out_valid);
      end
    end
    if (r) begin
      for (int k = 0; k < q.size(); k++) begin
        q[k].v   = 1'b0;
        q[k].tag = "R7";
      end
    end
    rst      = r;
    in_valid = v;
    op_a     = a;
    op_b     = b;
    carry_in = c;
    prev_r   = r;
    e.v   = v && !r;
    e.r   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    e.tag = r ? "R7" : (v ? tag : "R4");
    q.push_back(e);
  endtask

  initial begin : wd
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    for (int k = 0; k < 3; k++) step(0, '0, '0, 0, 1, "R7");
    // Directed corners, back to back
    step(1, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 0, "R6");
    step(1, 32'hFFFFFFFF, 32'h00000001, 0, 0, "R5");
    step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, "R5");
    step(1, 32'h000000FF, 32'h00000001, 0, 0, "R5");
    step(1, 32'h0000FFFF, 32'h00000001, 0, 0, "R5");
    step(1, 32'h00FFFFFF, 32'h00000000, 1, 0, "R6");
    step(1, 32'h00000000, 32'h00000000, 0, 0, "R1");
    step(1, 32'h12345678, 32'h87654321, 0, 0, "R1");
    step(1, 32'h80000000, 32'h80000000, 0, 0, "R5");
    // Idle gap with garbage operands
    for (int k = 0; k < 3; k++) step(0, 32'hDEADBEEF, 32'hCAFEF00D, 1, 0, "R4");
    // Mixed random traffic
    for (int k = 0; k < 150; k++)
      step(($urandom % 4) != 0, $urandom, $urandom, $urandom % 2, 0, "R1");
    // Unbroken back-to-back stream
    for (int k = 0; k < 40; k++)
      step(1, $urandom, $urandom, $urandom % 2, 0, "R3");
    // Reset while results are in flight
    for (int k = 0; k < 4; k++) step(1, $urandom, $urandom, 1, 0, "R3");
    step(1, 32'hFFFFFFFF, 32'h1, 0, 1, "R7");
    step(0, '0, '0, 0, 1, "R7");
    for (int k = 0; k < 8; k++) step(0, $urandom, $urandom, 0, 0, "R7");
    for (int k = 0; k < 20; k++)
      step(1, $urandom, $urandom, $urandom % 2, 0, "R3");
    // Drain
    for (int k = 0; k < DUE + 2; k++) step(0, '0, '0, 0, 0, "R4");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule